// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block records which reset sources have fired since software last looked, and keeps that record through every reset except power-on. Seven single-cycle event inputs, one per reset source, are sampled on a free-running clock. Each event sets a cause bit. The bits accumulate until software clears them. The storage flops take only the power-on reset as their asynchronous reset, so warm resets elsewhere in the chip leave the record intact. When power-on reset is released, the power-on cause is the only bit that is set.

Software reaches the block through a small word-addressed register bus with a combinational read path. The bus has three registers. The first is a read-only cause view in the older bit layout. The second is a clear register: writing 1 to its bit 0 empties the cause view. The third is a persistent 32-bit status word. Software owns this word, except that its bits 22:16 also collect the same causes. Those mirror bits are cleared only through the status word itself.

Top module: `rst_cause_recorder`

## Requirements
- R1: After por_n is released, the cause view (address 0) reads 0x0000_0040, the status word (address 2) reads 0x0040_0000, and address 3 reads 0.
- R2: A pulse on rst_evt[i] sets cause i on the next clock edge. The source order is: 0 system watchdog, 1 CPU0 watchdog, 2 CPU1 watchdog, 3 software system reset, 4 debug, 5 external reset pin, 6 power-on.
- R3: Causes accumulate across events, and with no event and no write the stored value does not change.
- R4: The cause view places the causes as follows: bit 6 power-on, bit 5 debug, bit 4 reset pin, bit 3 CPU1 watchdog, bit 2 CPU0 watchdog, bit 1 system watchdog, bit 0 software reset. Bits 31:7 read 0.
- R5: A write to address 1 with wdata[0]=1 clears every cause in the view. A write to address 1 with wdata[0]=0 has no effect, and a write to address 0 has no effect.
- R6: When an event and a clear land in the same cycle, that event's cause bit is still set afterwards.
- R7: Status bits 31:24 and 15:0 take the written data on a write to address 2, and events never alter them.
- R8: Status bits 22:16 hold cause i at bit 16+i. A status write loads them from wdata, and a same-cycle event wins for its bit. A write to the clear register leaves them unchanged.
- R9: Status bit 23 always reads 0. A write to address 3 is ignored, and address 3 reads 0.
- R10: Only por_n clears the storage. Asserting it again returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_evt | input | 7 | Single-cycle reset-event pulses, in the order given in R2 |
| bus_addr | input | 2 | Word address: 0 cause view, 1 clear, 2 status word, 3 unused |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The assertions assume two things about the inputs. Each rst_evt bit is a clean pulse sampled at the clock edge, and bus_we is valid only with a stable address and data in the same cycle. The bench drives every input at the falling edge and keeps each write and each event to exactly one cycle. It reads back only through bus_rdata, half a cycle after the edge that updates the state. The collision checks put an event and a write in the same cycle on purpose, because that is the one overlap the design defines.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int N_SRC   = 7;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int MIR_LSB = 16;
  localparam int RSV_BIT = 23;
  localparam int POR_IDX = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_REASON = 2'd0,
    A_CLEAR  = 2'd1,
    A_STATUS = 2'd2,
    A_HOLE   = 2'd3
  } rcr_addr_e;

  // cause index -> bit position in the older layout
  function automatic int legacy_pos(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 0;
      4: return 5;
      5: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] legacy_view(input logic [N_SRC-1:0] c);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_SRC; i++) r[legacy_pos(i)] = c[i];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] status_view(input logic [DATA_W-1:0] gp,
                                                     input logic [N_SRC-1:0] mir);
    logic [DATA_W-1:0] r;
    r = gp;
    r[MIR_LSB +: N_SRC] = mir;
    r[RSV_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/rcr_sticky_bits.sv
module rcr_sticky_bits #(
  parameter int           W       = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] set,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        q[i] <= RST_VAL[i];
      else if (set[i])   q[i] <= 1'b1;
      else if (load)     q[i] <= load_val[i];
      else if (clr)      q[i] <= 1'b0;
    end

    // R2, R6: hardware set always lands, whatever software does
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!por_n)
      set[i] |=> q[i]);
    // R3: nothing touches the bit -> it holds
    a_r3_bit_holds: assert property (@(posedge clk) disable iff (!por_n)
      (!set[i] && !load && !clr) |=> $stable(q[i]));
  end
endmodule

// File: rtl/rcr_gp_word.sv
module rcr_gp_word #(
  parameter int W       = 32,
  parameter int MIR_LSB = 16,
  parameter int MIR_W   = 7,
  parameter int RSV_BIT = 23
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if ((i >= MIR_LSB && i < MIR_LSB + MIR_W) || i == RSV_BIT) begin : g_none
      assign q[i] = 1'b0;
    end else begin : g_ff
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)  q[i] <= 1'b0;
        else if (we) q[i] <= wdata[i];
      end
    end
  end

  // R7: only a software write changes the general-purpose bits
  a_r7_hw_untouched: assert property (@(posedge clk) disable iff (!por_n)
    !we |=> $stable(q));
endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux
  import rcr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  cause,
  input  logic [DATA_W-1:0] gp,
  input  logic [N_SRC-1:0]  mir,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    case (rcr_addr_e'(addr))
      A_REASON: rdata = legacy_view(cause);
      A_STATUS: rdata = status_view(gp, mir);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rst_cause_recorder.sv
module rst_cause_recorder
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic [N_SRC-1:0]  rst_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [N_SRC-1:0] POR_ONLY = N_SRC'(1) << POR_IDX;

  logic              wr_clear;
  logic              wr_status;
  logic [N_SRC-1:0]  cause_q;
  logic [N_SRC-1:0]  mir_q;
  logic [DATA_W-1:0] gp_q;

  assign wr_clear  = bus_we && (bus_addr == A_CLEAR) && bus_wdata[0];
  assign wr_status = bus_we && (bus_addr == A_STATUS);

  rcr_sticky_bits #(.W(N_SRC), .RST_VAL(POR_ONLY)) u_cause (
    .clk(clk), .por_n(por_n), .set(rst_evt), .load(1'b0),
    .load_val('0), .clr(wr_clear), .q(cause_q));

  rcr_sticky_bits #(.W(N_SRC), .RST_VAL(POR_ONLY)) u_mirror (
    .clk(clk), .por_n(por_n), .set(rst_evt), .load(wr_status),
    .load_val(bus_wdata[MIR_LSB +: N_SRC]), .clr(1'b0), .q(mir_q));

  rcr_gp_word #(.W(DATA_W), .MIR_LSB(MIR_LSB), .MIR_W(N_SRC), .RSV_BIT(RSV_BIT)) u_gp (
    .clk(clk), .por_n(por_n), .we(wr_status), .wdata(bus_wdata), .q(gp_q));

  rcr_read_mux u_rd (
    .addr(bus_addr), .cause(cause_q), .gp(gp_q), .mir(mir_q), .rdata(bus_rdata));

  // R5: a clear with no concurrent event empties the cause view
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!por_n)
    (wr_clear && rst_evt == '0) |=> (bus_addr != A_REASON || bus_rdata == '0));
  // R8: status write loads the mirror when no event competes
  a_r8_mirror_load: assert property (@(posedge clk) disable iff (!por_n)
    (wr_status && rst_evt == '0) |=> mir_q == $past(bus_wdata[MIR_LSB +: N_SRC]));
  // R8: clearing the cause view spares the mirror
  a_r8_clear_spares: assert property (@(posedge clk) disable iff (!por_n)
    (wr_clear && rst_evt == '0) |=> $stable(mir_q));
  // R9: reserved bit and unused address read zero
  a_r9_rsv_zero: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == A_STATUS) |-> !bus_rdata[RSV_BIT]);
  a_r9_hole_zero: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == A_HOLE) |-> bus_rdata == '0);
endmodule

// File: tb/rst_cause_recorder_tb.sv
module rst_cause_recorder_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [6:0]  rst_evt = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0, bad = 0;
  logic [6:0]  m_cause, m_mir;
  logic [31:0] m_gp;

  rst_cause_recorder u_dut (.clk(clk), .por_n(por_n), .rst_evt(rst_evt),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_reason(input logic [6:0] c);
    return {25'd0, c[6], c[4], c[5], c[2], c[1], c[0], c[3]};
  endfunction
  function automatic logic [31:0] exp_status();
    return (m_gp & 32'hFF00_FFFF) | ({25'd0, m_mir} << 16);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(2'd0, v); check({tag, " reason"}, v, exp_reason(m_cause));
    rd(2'd2, v); check({tag, " status"}, v, exp_status());
    rd(2'd3, v); check({tag, " hole"}, v, 32'd0);
  endtask

  task automatic step(input logic [6:0] e, input logic we, input logic [1:0] a,
                      input logic [31:0] d);
    rst_evt = e; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (we && a == 2'd2) begin m_mir = d[22:16]; m_gp = d & 32'hFF00_FFFF; end
    if (we && a == 2'd1 && d[0]) m_cause = '0;
    m_cause = m_cause | e;
    m_mir   = m_mir | e;
    @(negedge clk);
    rst_evt = '0; bus_we = 1'b0;
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    m_cause = 7'h40; m_mir = 7'h40; m_gp = '0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    power_on();
    check_all("R1 por state");

    step(7'd0, 1'b1, 2'd1, 32'd1);
    check_all("R5 R8 clear spares mirror");

    // R2 R4: each source alone, mirror emptied by status write each round
    for (int i = 0; i < 7; i++) begin
      step(7'd1 << i, 1'b0, 2'd0, 32'd0);
      check_all($sformatf("R2 R4 R8 single src %0d", i));
      step(7'd0, 1'b1, 2'd1, 32'hFFFF_FFFF);
      step(7'd0, 1'b1, 2'd2, 32'd0);
      check_all($sformatf("R5 R8 cleared after src %0d", i));
    end

    // R3: accumulation and hold
    step(7'h01, 1'b0, 2'd0, 32'd0);
    step(7'h20, 1'b0, 2'd0, 32'd0);
    step(7'h08, 1'b0, 2'd0, 32'd0);
    repeat (5) step(7'd0, 1'b0, 2'd0, 32'd0);
    check_all("R3 accumulate and hold");

    // R5: writes without effect
    step(7'd0, 1'b1, 2'd1, 32'hFFFF_FFFE);
    check_all("R5 clear bit0 zero");
    step(7'd0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    check_all("R5 write to view ignored");

    // R6: event colliding with clear
    step(7'h04, 1'b1, 2'd1, 32'd1);
    check_all("R6 event wins over clear");
    step(7'h7F, 1'b0, 2'd0, 32'd0);
    check_all("R2 all sources at once");

    // R8: event colliding with status write
    step(7'h10, 1'b1, 2'd2, 32'h0000_0000);
    check_all("R8 event wins over status write");

    // R7 R9: sweep of write patterns on the status word
    for (int k = 0; k < 16; k++) begin
      logic [31:0] pat;
      pat = (32'h1111_1111 * k) ^ (32'hA5C3_0F69 >> k);
      step(7'd0, 1'b1, 2'd2, pat);
      check_all($sformatf("R7 R9 pattern %0d", k));
    end
    step(7'd0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    check_all("R9 rsv bit reads 0");

    step(7'h7F, 1'b0, 2'd0, 32'd0);
    check_all("R7 events leave gp bits");

    step(7'd0, 1'b1, 2'd3, 32'hFFFF_FFFF);
    check_all("R9 hole write ignored");

    // R10: only power-on clears
    step(7'h2A, 1'b0, 2'd0, 32'd0);
    power_on();
    check_all("R10 por restores");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule